// File: doc/BRIEF.md
# LCD Panel Scan Timing Generator

This block produces every scan-control waveform needed by a small thin-film-transistor panel that has shift-register row and column drivers built into the glass. It works from a master clock and two sync markers. The `line_sync` marker starts each horizontal period. The `field_sync` marker arms the start of a field. From these the block derives several outputs:

- a horizontal start pulse and two complementary horizontal shift clocks;
- a vertical start pulse and a vertical shift clock that changes level once per line;
- a gate-enable window and a uniformity-control pulse, both placed at fixed tick offsets from the vertical clock transition;
- a polarity flag that inverts on every line;
- two direction levels, registered from the host settings.

The panel's pixels sit in a delta pattern, so on every odd line of a field the horizontal start and its shift clocks are delayed by a fixed number of ticks (1.5 dots). For 50 Hz sources a PAL select removes one line in every `PAL_PERIOD`. On a removed line the gate enable and the uniformity pulse stay low and the vertical clock is frozen, so a taller field still fills exactly `FIELD_LINES` panel rows. All offsets are whole master-clock ticks, counted from line sync.

The edge that samples `line_sync` high starts tick 0 of a line. Each later edge starts the next tick. An event "at tick n" means the output takes its new value at the edge that starts tick n. Line 0 of a field is the first line whose sync follows a sampled `field_sync`.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `rst` is high, and afterwards until the first `line_sync`, every pulse output, `v_clk` and `pol_flag` are 0. In the same period `hclk_a` is 0 and `hclk_b` is 1.
- R2: `hclk_b` is always the inverse of `hclk_a`.
- R3: On each line `hclk_a` rises first at tick base+`HALF_TICKS`. It toggles every `HALF_TICKS` ticks and gives exactly `HCLK_CYCLES` rising edges. Its last fall is at tick base+2·`HCLK_CYCLES`·`HALF_TICKS`, after which it stays low. Here base is the start tick defined in R4 and R5.
- R4: `h_start` rises at tick base and falls at tick base+2·`HALF_TICKS`. It is therefore high `HALF_TICKS` ticks before the first `hclk_a` rise, and it falls together with the first `hclk_a` fall.
- R5: base is `HSTART_TICK` on even lines of a field and `HSTART_TICK`+`DELTA_TICKS` on odd lines.
- R6: `pol_flag` is 0 during the first line after reset and inverts at every later `line_sync`.
- R7: `v_clk` changes level once, at tick `VCLK_TICK`, on each live line. A live line is a line with index 1 or more, that is not dropped, and that comes before `FIELD_LINES` transitions have occurred in the field. Each field therefore gives exactly `FIELD_LINES` transitions. Line 0 and lines after the last transition give none.
- R8: `v_start` rises at tick `VSTART_TICK` of line 0 and falls at tick `VSTART_TICK` of line 1.
- R9: On a live line `gate_en` is high from tick `VCLK_TICK`−`GATE_LEAD`−`GATE_WIDTH` to tick `VCLK_TICK`−`GATE_LEAD`. It is low otherwise.
- R10: On a live line `unif_pulse` is high from tick `VCLK_TICK`−`UNIF_LEAD` to tick `VCLK_TICK`−`UNIF_LEAD`+`UNIF_WIDTH`. It is low otherwise.
- R11: The `pal_sel` value is taken at each `line_sync`. When that value is 1, a line whose index modulo `PAL_PERIOD` equals `PAL_PERIOD`−1 is dropped. A dropped line has no `v_clk` transition, no `gate_en` pulse and no `unif_pulse`. When the value is 0, no line is dropped.
- R12: `dir_h` and `dir_v` follow `scan_lr` and `scan_tb` one clock later. A value of 1 means left-to-right and top-to-bottom respectively. Both are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master tick clock |
| rst | input | 1 | Synchronous reset, active high |
| line_sync | input | 1 | One-cycle marker that starts a horizontal period |
| field_sync | input | 1 | One-cycle marker; the next line is line 0 |
| pal_sel | input | 1 | 1 enables PAL line dropping |
| scan_lr | input | 1 | Horizontal scan direction setting |
| scan_tb | input | 1 | Vertical scan direction setting |
| h_start | output | 1 | Horizontal start pulse |
| hclk_a | output | 1 | Horizontal shift clock |
| hclk_b | output | 1 | Complement of `hclk_a` |
| v_start | output | 1 | Vertical start pulse |
| v_clk | output | 1 | Vertical shift clock, one transition per line |
| gate_en | output | 1 | Gate-drive enable window |
| unif_pulse | output | 1 | Uniformity-control pulse |
| pol_flag | output | 1 | Per-line video polarity |
| dir_h | output | 1 | Horizontal direction level |
| dir_v | output | 1 | Vertical direction level |

## Verification
The bench follows full fields in both modes and measures every edge tick on each line. It targets four corner cases:

- **Delta shift on odd lines.** A design that takes the shift from the free-running polarity flag, instead of the line index, would misplace the start pulse after an odd number of lines.
- **Last vertical transition.** A design with an off-by-one in the transition budget would clock a 241st row, or stop one row short.
- **PAL dropping.** A design that gated only the enable would keep advancing `v_clk` on dropped lines and run out of rows early. A design that sampled `pal_sel` mid-line would drop the wrong rows.
- **Start-pulse hold against the clock fall.** A start pulse one tick too long or short would shift every column sample.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int HALF_TICKS  = 4,
  parameter int DELTA_TICKS = 2,
  parameter int HCLK_CYCLES = 82,
  parameter int HSTART_TICK = 96,
  parameter int VCLK_TICK   = 60,
  parameter int GATE_WIDTH  = 36,
  parameter int GATE_LEAD   = 7,
  parameter int UNIF_WIDTH  = 18,
  parameter int UNIF_LEAD   = 6,
  parameter int VSTART_TICK = 444,
  parameter int FIELD_LINES = 240,
  parameter int PAL_PERIOD  = 6,
  parameter int CNT_W       = 11,
  parameter int LINE_W      = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic line_sync,
  input  logic field_sync,
  input  logic pal_sel,
  input  logic scan_lr,
  input  logic scan_tb,
  output logic h_start,
  output logic hclk_a,
  output logic hclk_b,
  output logic v_start,
  output logic v_clk,
  output logic gate_en,
  output logic unif_pulse,
  output logic pol_flag,
  output logic dir_h,
  output logic dir_v
);

  localparam int HH_W  = $clog2(2*HCLK_CYCLES + 1);
  localparam int SUB_W = $clog2(HALF_TICKS + 1);
  localparam int EC_W  = $clog2(FIELD_LINES + 1);
  localparam int PC_W  = (PAL_PERIOD > 1) ? $clog2(PAL_PERIOD) : 1;

  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [CNT_W-1:0]  GATE_ON  = CNT_W'(VCLK_TICK - GATE_LEAD - GATE_WIDTH - 1);
  localparam logic [CNT_W-1:0]  GATE_OFF = CNT_W'(VCLK_TICK - GATE_LEAD - 1);
  localparam logic [CNT_W-1:0]  UNIF_ON  = CNT_W'(VCLK_TICK - UNIF_LEAD - 1);
  localparam logic [CNT_W-1:0]  UNIF_OFF = CNT_W'(VCLK_TICK - UNIF_LEAD + UNIF_WIDTH - 1);
  localparam logic [CNT_W-1:0]  VCLK_AT  = CNT_W'(VCLK_TICK - 1);
  localparam logic [CNT_W-1:0]  VST_AT   = CNT_W'(VSTART_TICK - 1);
  localparam logic [SUB_W-1:0]  SUB_END  = SUB_W'(HALF_TICKS);
  localparam logic [HH_W-1:0]   HALF_END = HH_W'(2*HCLK_CYCLES);
  localparam logic [PC_W-1:0]   PC_LAST  = PC_W'(PAL_PERIOD - 1);
  localparam logic [EC_W-1:0]   EC_FULL  = EC_W'(FIELD_LINES);

  logic [CNT_W-1:0]  hcnt;
  logic [LINE_W-1:0] lcnt;
  logic [EC_W-1:0]   ecnt;
  logic [PC_W-1:0]   pcnt;
  logic [SUB_W-1:0]  hsub;
  logic [HH_W-1:0]   hhalf;
  logic              synced, field_pend, pal_q, hrun;

  logic [CNT_W-1:0] hbase_m1, hst_off_m1, hck_on_m1;
  assign hbase_m1   = CNT_W'(HSTART_TICK - 1) + (lcnt[0] ? CNT_W'(DELTA_TICKS) : '0);
  assign hst_off_m1 = hbase_m1 + CNT_W'(2*HALF_TICKS);
  assign hck_on_m1  = hbase_m1 + CNT_W'(HALF_TICKS);

  logic drop, live;
  assign drop = pal_q && (pcnt == PC_LAST);
  assign live = (lcnt != '0) && (ecnt < EC_FULL) && !drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0; lcnt <= LINE_MAX; ecnt <= EC_FULL; pcnt <= '0;
      hsub <= '0; hhalf <= '0; hrun <= 1'b0;
      synced <= 1'b0; field_pend <= 1'b0; pal_q <= 1'b0;
      h_start <= 1'b0; hclk_a <= 1'b0; hclk_b <= 1'b1;
      v_start <= 1'b0; v_clk <= 1'b0; gate_en <= 1'b0; unif_pulse <= 1'b0;
      pol_flag <= 1'b0; dir_h <= 1'b0; dir_v <= 1'b0;
    end else begin
      dir_h <= scan_lr;
      dir_v <= scan_tb;
      if (line_sync) begin
        hcnt     <= '0;
        synced   <= 1'b1;
        pol_flag <= synced ? ~pol_flag : 1'b0;
        pal_q    <= pal_sel;
        h_start  <= 1'b0;
        hclk_a   <= 1'b0;
        hclk_b   <= 1'b1;
        hrun     <= 1'b0;
        if (field_pend) begin
          lcnt <= '0; pcnt <= '0; ecnt <= '0;
          field_pend <= 1'b0;
        end else begin
          if (lcnt != LINE_MAX) lcnt <= lcnt + 1'b1;
          pcnt <= (pcnt == PC_LAST) ? '0 : pcnt + 1'b1;
        end
      end else if (synced) begin
        if (hcnt != CNT_MAX) hcnt <= hcnt + 1'b1;

        if (hcnt == hbase_m1)   h_start <= 1'b1;
        if (hcnt == hst_off_m1) h_start <= 1'b0;

        if (hcnt == hck_on_m1) begin
          hclk_a <= 1'b1; hclk_b <= 1'b0;
          hrun <= 1'b1; hsub <= SUB_W'(1); hhalf <= HH_W'(1);
        end else if (hrun) begin
          if (hsub == SUB_END) begin
            hsub <= SUB_W'(1);
            if (hhalf == HALF_END) begin
              hrun <= 1'b0; hclk_a <= 1'b0; hclk_b <= 1'b1;
            end else begin
              hclk_a <= ~hclk_a; hclk_b <= ~hclk_b;
              hhalf <= hhalf + 1'b1;
            end
          end else begin
            hsub <= hsub + 1'b1;
          end
        end

        if (hcnt == GATE_ON && live) gate_en <= 1'b1;
        if (hcnt == GATE_OFF)        gate_en <= 1'b0;
        if (hcnt == UNIF_ON && live) unif_pulse <= 1'b1;
        if (hcnt == UNIF_OFF)        unif_pulse <= 1'b0;
        if (hcnt == VCLK_AT && live) begin
          v_clk <= ~v_clk;
          ecnt  <= ecnt + 1'b1;
        end
        if (hcnt == VST_AT) v_start <= (lcnt == '0);
      end
      if (field_sync) field_pend <= 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!h_start && !gate_en && !v_clk && !unif_pulse && !v_start &&
             !pol_flag && !hclk_a && hclk_b));

  assert_hclk_compl_R2: assert property (@(posedge clk) disable iff (rst)
    hclk_a != hclk_b);

  assert_hstart_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(h_start) |-> (!hclk_a && hclk_b));

  assert_hstart_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(h_start) |-> $fell(hclk_a));

  assert_pol_on_sync_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(pol_flag) |-> $past(line_sync));

  assert_vclk_window_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(v_clk) |-> (unif_pulse && !gate_en));

endmodule

// File: tb/lcd_scan_timer_test.sv
`timescale 1ns/1ps
module lcd_scan_timer_test;
  localparam int HALF = 4, DELTA = 2, CYC = 6, HST = 90, TV = 60;
  localparam int GW = 36, GL = 7, UW = 18, UL = 6, VON = 140, NL = 8, PP = 3;
  localparam int LINE = 160;

  logic clk = 1'b0, rst = 1'b1, line_sync = 1'b0, field_sync = 1'b0;
  logic pal_sel = 1'b0, scan_lr = 1'b0, scan_tb = 1'b0;
  logic h_start, hclk_a, hclk_b, v_start, v_clk, gate_en, unif_pulse, pol_flag, dir_h, dir_v;

  lcd_scan_timer #(.HALF_TICKS(HALF), .DELTA_TICKS(DELTA), .HCLK_CYCLES(CYC),
    .HSTART_TICK(HST), .VCLK_TICK(TV), .GATE_WIDTH(GW), .GATE_LEAD(GL),
    .UNIF_WIDTH(UW), .UNIF_LEAD(UL), .VSTART_TICK(VON), .FIELD_LINES(NL),
    .PAL_PERIOD(PP), .CNT_W(9), .LINE_W(6)) uut (
    .clk(clk), .rst(rst), .line_sync(line_sync), .field_sync(field_sync),
    .pal_sel(pal_sel), .scan_lr(scan_lr), .scan_tb(scan_tb),
    .h_start(h_start), .hclk_a(hclk_a), .hclk_b(hclk_b), .v_start(v_start),
    .v_clk(v_clk), .gate_en(gate_en), .unif_pulse(unif_pulse),
    .pol_flag(pol_flag), .dir_h(dir_h), .dir_v(dir_v));

  always #2.5 clk = ~clk;

  int nvec = 0, nbad = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nbad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  logic p_hst, p_ha, p_vck, p_en, p_wd, p_vst;
  int hst_r, hst_f, hck_r1, hck_n, hck_lf, compl_bad;
  int en_r, en_f, en_n, wd_r, wd_f, wd_n, vck_n, vck_t, vst_r, vst_f, vst_n, frp_v;
  int last_frp = -1;

  task automatic observe(input int tk);
    if (h_start && !p_hst && hst_r < 0) hst_r = tk;
    if (!h_start && p_hst) hst_f = tk;
    if (hclk_a && !p_ha) begin hck_n++; if (hck_r1 < 0) hck_r1 = tk; end
    if (!hclk_a && p_ha) hck_lf = tk;
    if (hclk_a == hclk_b) compl_bad++;
    if (gate_en && !p_en) begin en_n++; en_r = tk; end
    if (!gate_en && p_en) en_f = tk;
    if (unif_pulse && !p_wd) begin wd_n++; wd_r = tk; end
    if (!unif_pulse && p_wd) wd_f = tk;
    if (v_clk != p_vck) begin vck_n++; vck_t = tk; end
    if (v_start != p_vst) begin vst_n++; if (v_start) vst_r = tk; else vst_f = tk; end
    if (tk == 1) frp_v = int'(pol_flag);
    p_hst = h_start; p_ha = hclk_a; p_vck = v_clk; p_en = gate_en;
    p_wd = unif_pulse; p_vst = v_start;
  endtask

  task automatic run_line(input int vs_tick);
    hst_r = -1; hst_f = -1; hck_r1 = -1; hck_n = 0; hck_lf = -1; compl_bad = 0;
    en_r = -1; en_f = -1; en_n = 0; wd_r = -1; wd_f = -1; wd_n = 0;
    vck_n = 0; vck_t = -1; vst_r = -1; vst_f = -1; vst_n = 0; frp_v = -1;
    for (int tk = 0; tk < LINE; tk++) begin
      @(negedge clk);
      if (tk == 0) line_sync = 1'b0;
      field_sync = (tk == vs_tick);
      observe(tk);
      if (tk == LINE - 1) line_sync = 1'b1;
    end
    if (last_frp < 0) chk("R6 first line polarity", frp_v, 0);
    else chk("R6 polarity alternates", frp_v, 1 - last_frp);
    last_frp = frp_v;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R1 hclk_b in reset", int'(hclk_b), 1);
    chk("R1 hclk_a in reset", int'(hclk_a), 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk("R1 pulses idle before sync",
        int'({h_start, v_start, v_clk, gate_en, unif_pulse, pol_flag}), 0);
    chk("R1 hclk parked before sync", int'({hclk_a, hclk_b}), 1);
    chk("R12 dir reset", int'({dir_h, dir_v}), 0);
  endtask

  task automatic t_dir;
    scan_lr = 1'b1; scan_tb = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 left-to-right, bottom-to-top", int'({dir_h, dir_v}), 2);
    scan_lr = 1'b0; scan_tb = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R12 right-to-left, top-to-bottom", int'({dir_h, dir_v}), 1);
  endtask

  task automatic t_field(input bit pal, input int nlines);
    int edges = 0;
    int base;
    bit elig;
    pal_sel = pal;
    run_line(10);
    for (int k = 0; k < nlines; k++) begin
      run_line(-1);
      base = HST + ((k % 2) ? DELTA : 0);
      chk("R5 start tick", hst_r, base);
      chk("R4 start fall", hst_f, base + 2*HALF);
      chk("R3 first clock rise", hck_r1, base + HALF);
      chk("R3 clock rises", hck_n, CYC);
      chk("R3 last clock fall", hck_lf, base + 2*CYC*HALF);
      chk("R2 complement", compl_bad, 0);
      elig = (k >= 1) && (edges < NL) && !(pal && (k % PP == PP - 1));
      if (elig) begin
        chk("R7 one vclk transition", vck_n, 1);
        chk("R7 vclk tick", vck_t, TV);
        chk("R9 gate rise", en_r, TV - GL - GW);
        chk("R9 gate fall", en_f, TV - GL);
        chk("R10 unif rise", wd_r, TV - UL);
        chk("R10 unif fall", wd_f, TV - UL + UW);
        edges++;
      end else if (pal && k >= 1 && (k % PP == PP - 1)) begin
        chk("R11 dropped line vclk frozen", vck_n, 0);
        chk("R11 dropped line gate low", en_n, 0);
        chk("R11 dropped line unif low", wd_n, 0);
      end else begin
        chk("R7 idle line vclk", vck_n, 0);
        chk("R9 idle line gate", en_n, 0);
        chk("R10 idle line unif", wd_n, 0);
      end
      if (k == 0) chk("R8 vstart rise", vst_r, VON);
      else if (k == 1) chk("R8 vstart fall", vst_f, VON);
      else chk("R8 vstart quiet", vst_n, 0);
    end
    chk("R7 transitions per field", edges, NL);
  endtask

  initial begin
    t_reset();
    t_dir();
    @(negedge clk);
    line_sync = 1'b1;
    t_field(1'b0, NL + 3);
    t_field(1'b1, 15);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule